// File: doc/BRIEF.md
# Triggered Register-Bank Writeback to Serial EEPROM

This block saves a bank of eight 32-bit registers into one fixed page of an external serial EEPROM. A rising edge on the trigger input makes it copy the bank into a shadow frame. It then drives a single write burst on a two-wire serial bus, clocked by a divider of the system clock. The burst has a START condition, the device byte, a two-byte memory address, the 32 register bytes and a STOP condition.

Both bus lines are driven open-drain style. A high on `scl_lo` or `sda_lo` pulls the line low, and a low releases it. The line state on SDA is read back through `sda_in`, so the block can sample the acknowledge bit after every byte. The block is meant as a last-gasp store of settings: the burst has a bounded length and runs without any software help.

Top module: `eeprom_bank_writer`

## Requirements
- R1: After reset, both bus lines are released (`scl_lo`=0, `sda_lo`=0), and `busy`, `done` and `nack_err` are all 0.
- R2: A rising edge of `wb_trig` seen while idle makes `busy` rise in the next cycle. The transfer then begins with a START condition, in which SDA falls while SCL is high.
- R3: The first three bytes on the bus, each sent most significant bit first, are the device byte 0x60, then the memory address high byte 0x00, then the low byte 0x20. The address 0x20 is byte 32, the start of the second 32-byte page.
- R4: The next 32 bytes are the registers in the order register 0 to register 7. Register i sits at `reg_bank[32*i+31:32*i]`, and each register is sent with its bits 31..24 first. After the 35th acknowledged byte the block issues a STOP condition, in which SDA rises while SCL is high.
- R5: The bytes sent are the values of `reg_bank` at the trigger edge. Changes to `reg_bank` during the transfer do not alter the burst.
- R6: Rising edges of `wb_trig` while `busy` is 1 are ignored. The burst keeps a single START and a single STOP, and its bytes are unchanged.
- R7: During data and acknowledge bits, SDA changes only while SCL is low.
- R8: If SDA reads high during the acknowledge bit of any byte, the block sends no further byte. It issues a STOP, sets `nack_err` to 1 and returns to idle.
- R9: `done` is a single-cycle pulse after the STOP condition completes, after both normal and error ends. In that cycle `busy` is already 0.
- R10: SCL runs with a period of 4*DIV system clock cycles, with equal high and low halves.
- R11: `nack_err` holds its value until the next accepted trigger, which clears it.
- R12: A trigger edge that lands in the cycle where `done` is high is accepted and starts a new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_trig | input | 1 | Writeback request; its rising edge starts a burst |
| reg_bank | input | 256 | Register bank; register i at bits 32*i+31..32*i |
| sda_in | input | 1 | Observed level of the SDA line |
| scl_lo | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_lo | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse after the STOP condition |
| nack_err | output | 1 | The last burst was ended by a missing acknowledge |

## Verification
Two things can fall in the same cycle here. The end of one burst, marked by the `done` pulse, can meet the acceptance of a new trigger edge. The bench provokes this by raising `wb_trig` exactly in the cycle where `done` is high. It then judges that `busy` rises at once and that the next burst carries the freshly captured bank. The same overlap is tried for an error end: a burst cut short by an acknowledge failure is followed by a new trigger. The bench checks that `nack_err` clears when the new burst starts, rather than staying set or clearing early.

// File: rtl/eeprom_bank_writer.sv
module eeprom_bank_writer #(
  parameter int DIV = 81,
  parameter int NREG = 8,
  parameter int RW = 32,
  parameter logic [7:0] DEV_BYTE = 8'h60,
  parameter logic [15:0] MEM_ADDR = 16'h0020
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wb_trig,
  input  logic [NREG*RW-1:0]  reg_bank,
  input  logic                sda_in,
  output logic                scl_lo,
  output logic                sda_lo,
  output logic                busy,
  output logic                done,
  output logic                nack_err
);
  localparam int BANKW = NREG * RW;
  localparam int NBYTES = 3 + BANKW / 8;
  localparam int FW = 8 * NBYTES;
  localparam int QW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BCW = $clog2(NBYTES);

  typedef enum logic [1:0] {S_IDLE, S_START, S_XFER, S_STOP} st_t;

  st_t            st;
  logic [QW-1:0]  qcnt;
  logic [1:0]     phase;
  logic [3:0]     bitcnt;
  logic [BCW-1:0] bytecnt;
  logic [FW-1:0]  frame, load;
  logic           trig_q, ack_bad;

  wire trig_edge = wb_trig & ~trig_q;
  wire tick = (qcnt == QW'(DIV - 1));
  wire ack_bit = (bitcnt == 4'd8);

  assign busy = (st != S_IDLE);
  assign scl_lo = ((st == S_XFER) || (st == S_STOP)) && !phase[1];

  always_comb begin
    load = '0;
    load[FW-1 -: 24] = {DEV_BYTE, MEM_ADDR};
    for (int i = 0; i < NREG; i++)
      load[BANKW-1-RW*i -: RW] = reg_bank[RW*i +: RW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      qcnt <= '0;
      phase <= '0;
      bitcnt <= '0;
      bytecnt <= '0;
      frame <= '0;
      trig_q <= 1'b0;
      ack_bad <= 1'b0;
      sda_lo <= 1'b0;
      done <= 1'b0;
      nack_err <= 1'b0;
    end else begin
      trig_q <= wb_trig;
      done <= 1'b0;
      if (st == S_IDLE) begin
        qcnt <= '0;
        phase <= '0;
        sda_lo <= 1'b0;
        if (trig_edge) begin
          frame <= load;
          st <= S_START;
          nack_err <= 1'b0;
          bitcnt <= '0;
          bytecnt <= '0;
          ack_bad <= 1'b0;
        end
      end else begin
        qcnt <= tick ? '0 : qcnt + 1'b1;
        if (tick) begin
          phase <= phase + 2'd1;
          case (st)
            S_START: begin
              if (phase == 2'd1) sda_lo <= 1'b1;
              if (phase == 2'd3) st <= S_XFER;
            end
            S_XFER: begin
              if (phase == 2'd0) sda_lo <= ack_bit ? 1'b0 : ~frame[FW-1];
              if (phase == 2'd2 && ack_bit) ack_bad <= sda_in;
              if (phase == 2'd3) begin
                if (ack_bit) begin
                  if (ack_bad || bytecnt == BCW'(NBYTES - 1)) begin
                    st <= S_STOP;
                    nack_err <= ack_bad;
                  end else begin
                    bitcnt <= '0;
                    bytecnt <= bytecnt + 1'b1;
                  end
                end else begin
                  bitcnt <= bitcnt + 4'd1;
                  frame <= {frame[FW-2:0], 1'b0};
                end
              end
            end
            S_STOP: begin
              if (phase == 2'd0) sda_lo <= 1'b1;
              if (phase == 2'd2) sda_lo <= 1'b0;
              if (phase == 2'd3) begin
                st <= S_IDLE;
                done <= 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  p_sda_quiet_scl_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && $past(st) == S_XFER && !scl_lo && !$past(scl_lo)) |-> $stable(sda_lo));

  p_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wb_trig && !trig_q) |=> busy);

  p_byte_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bytecnt < BCW'(NBYTES)));

  p_err_at_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> (st == S_STOP));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tb_eeprom_bank_writer.sv
`timescale 1ns/1ps
module tb_eeprom_bank_writer;
  localparam int TDIV = 3;
  localparam int NREG = 8;
  localparam int BW = NREG * 32;
  localparam int NB = 3 + NREG * 4;

  logic clk = 0, rst_n = 0, wb_trig = 0;
  logic [BW-1:0] reg_bank = '0;
  logic scl_lo, sda_lo, busy, done, nack_err, sda_in;
  logic slv_drv = 0;
  wire scl = ~scl_lo;
  assign sda_in = ~(sda_lo | slv_drv);

  eeprom_bank_writer #(.DIV(TDIV)) dut (
    .clk(clk), .rst_n(rst_n), .wb_trig(wb_trig), .reg_bank(reg_bank),
    .sda_in(sda_in), .scl_lo(scl_lo), .sda_lo(sda_lo), .busy(busy),
    .done(done), .nack_err(nack_err));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int starts = 0, stops = 0, nrx = 0, bitc = 0, nack_idx = -1;
  logic [7:0] shreg = 0;
  logic [7:0] rx [0:63];
  realtime last_rise = 0, pmin = 1e9, pmax = 0;

  always @(negedge sda_in) if (scl) begin starts++; nrx = 0; bitc = 0; last_rise = 0; end
  always @(posedge sda_in) if (scl) stops++;
  always @(posedge scl) begin
    if (last_rise != 0) begin
      if ($realtime - last_rise < pmin) pmin = $realtime - last_rise;
      if ($realtime - last_rise > pmax) pmax = $realtime - last_rise;
    end
    last_rise = $realtime;
    if (bitc < 8) begin
      shreg = {shreg[6:0], sda_in};
      bitc++;
      if (bitc == 8) begin rx[nrx] = shreg; nrx++; end
    end else bitc = 0;
  end
  always @(negedge scl) slv_drv = (bitc == 8) && (nrx - 1 != nack_idx);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [BW-1:0] b, input int k);
    if (k == 0) return 8'h60;
    if (k == 1) return 8'h00;
    if (k == 2) return 8'h20;
    return b[32*((k-3)/4) + 8*(3-((k-3)%4)) +: 8];
  endfunction

  function automatic logic [BW-1:0] rand_bank();
    logic [BW-1:0] b;
    for (int i = 0; i < NREG; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  task automatic mon_clear();
    starts = 0; stops = 0; nrx = 0; bitc = 0;
    pmin = 1e9; pmax = 0; last_rise = 0;
  endtask

  task automatic pulse_trig();
    wb_trig = 1;
    @(negedge clk);
    wb_trig = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    chk(ok, "R9 done reached", ok, 1);
    if (ok) chk(!busy, "R9 busy low with done", busy, 0);
  endtask

  task automatic check_frame(input logic [BW-1:0] b, input int nk, input string tag);
    int exp_n = (nk < 0) ? NB : nk + 1;
    chk(nrx == exp_n, {tag, " R4 byte count"}, nrx, exp_n);
    chk(starts == 1, {tag, " R2 single START"}, starts, 1);
    chk(stops == 1, {tag, " R7 single STOP"}, stops, 1);
    for (int k = 0; k < exp_n && k < 64; k++)
      if (rx[k] != exp_byte(b, k)) begin
        chk(0, (k < 3) ? {tag, " R3 header byte"} : {tag, " R4 data byte"}, rx[k], exp_byte(b, k));
        break;
      end
    chk(rx[0] == 8'h60 && rx[1] == 8'h00 && rx[2] == 8'h20, {tag, " R3 header"}, rx[2], 8'h20);
    chk(nack_err == (nk >= 0), {tag, " R8 error flag"}, nack_err, nk >= 0);
    chk(pmin == pmax && pmax == 4 * TDIV * 8, {tag, " R10 SCL period"}, int'(pmax), 4 * TDIV * 8);
  endtask

  task automatic run(input int nk, input bit disturb, input string tag);
    logic [BW-1:0] b;
    bit ok;
    b = rand_bank();
    reg_bank = b;
    nack_idx = nk;
    mon_clear();
    pulse_trig();
    chk(busy == 1, {tag, " R2 busy after edge"}, busy, 1);
    chk(nack_err == 0, {tag, " R11 error cleared"}, nack_err, 0);
    if (disturb) begin
      for (int j = 0; j < 6; j++) begin
        repeat (100 + $urandom % 300) @(negedge clk);
        reg_bank = rand_bank();
        pulse_trig();
      end
    end
    wait_done(ok);
    @(negedge clk);
    chk(!done, {tag, " R9 done one cycle"}, done, 0);
    check_frame(b, nk, tag);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [BW-1:0] b2;
    bit ok;
    int unsigned seed;
    seed = $urandom(32'h1701);
    repeat (3) @(negedge clk);
    chk(scl_lo == 0 && sda_lo == 0, "R1 lines released", {scl_lo, sda_lo}, 0);
    chk(busy == 0 && done == 0 && nack_err == 0, "R1 flags clear", {busy, done, nack_err}, 0);
    rst_n = 1;
    @(negedge clk);
    run(-1, 0, "basic");
    run(-1, 1, "R5 R6 disturbed");
    run(0, 0, "R8 nack device byte");
    run(3 + $urandom % 32, 0, "R8 nack data byte");
    chk(nack_err == 1, "R11 error held", nack_err, 1);
    run(-1, 0, "R11 after error");
    run(5 + $urandom % 20, 0, "R8 second nack");
    // R12: new trigger in the done cycle
    reg_bank = rand_bank();
    nack_idx = -1;
    mon_clear();
    pulse_trig();
    wait_done(ok);
    b2 = rand_bank();
    reg_bank = b2;
    mon_clear();
    pulse_trig();
    chk(busy == 1, "R12 trigger in done cycle accepted", busy, 1);
    wait_done(ok);
    check_frame(b2, -1, "R12");
    for (int r = 0; r < 3; r++) run(-1, r[0], "random");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule